// File: doc/BRIEF.md
# Strided Tile Transfer Engine

This block moves one two-dimensional tile between a word-addressed memory port and a small on-block tile register file. Each tile has a shape (a row count and a byte count per row) supplied by the configuration inputs. A command selects a tile, an operation, a base word address and a row stride in words. The engine then walks the tile row by row. Row r sits at base + r * stride, and the words of a row are moved in ascending address order.

Four operations exist: a plain load, a streaming load that is identical except for a non-temporal hint on every memory request, a store, and a zero that clears the configured area of the tile without touching memory. The memory side carries one outstanding request at a time: the engine raises a one-cycle request and waits for an acknowledge before it issues the next one. Commands are rejected with an error pulse when the configuration is not valid or the selected tile's shape is out of range.

Top module: `tile_xfer_engine`

## Requirements
- R1: For loads and stores, the k-th memory request of a command addresses base + r*stride + w (modulo 2^AW), where r = k / W, w = k % W and W = bytes-per-row / 4. Exactly rows*W requests are made and at most one is outstanding at any time.
- R2: A plain load (cmd_op = 0) writes the acknowledged word of request (r, w) into tile row r, word w. Word w holds row bytes 4w..4w+3. Every tile word outside the configured rows and words reads as zero after the load.
- R3: A streaming load (cmd_op = 1) leaves the same tile contents as a plain load and drives mem_nt high on each of its requests. Every other operation drives mem_nt low.
- R4: A store (cmd_op = 2) issues write requests (mem_we = 1) whose data is tile row r, word w. Tile contents are unchanged.
- R5: A zero (cmd_op = 3) makes no memory request. It sets the configured rows x words area of the tile to zero and leaves the rest of the tile unchanged.
- R6: The shape comes from the selected tile's configuration fields (tile t uses cfg_rows[5t+4:5t] and cfg_bytes[7t+6:7t]). A command is rejected when cfg_ok is low, the row count is 0 or above 16, or the byte count is 0, above 64 or not a multiple of 4. A rejected command gives a one-cycle err pulse in the cycle after acceptance, with no busy, no request and no tile change.
- R7: busy is high from the cycle after an accepted command until the operation completes. done is a one-cycle pulse in the first cycle that busy is low again.
- R8: cmd_valid is ignored while busy is high.
- R9: After reset busy, done, err and mem_req are low, and every tile word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ok | input | 1 | Configuration valid |
| cfg_rows | input | NT*5 | Row count per tile |
| cfg_bytes | input | NT*7 | Bytes per row per tile |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 0 load, 1 streaming load, 2 store, 3 zero |
| cmd_tile | input | TW | Selected tile |
| cmd_base | input | AW | Base word address |
| cmd_stride | input | AW | Row stride in words |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Rejection pulse |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_nt | output | 1 | Non-temporal hint |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tile_rd_tile | input | TW | Tile read port: tile |
| tile_rd_row | input | 4 | Tile read port: row |
| tile_rd_word | input | 4 | Tile read port: word |
| tile_rd_data | output | 32 | Tile read port: data |

## Verification
A wrong row or word counter shows up on the memory port at once, as a request address that leaves the base + r*stride + w sequence, and later as a wrong request count or a done pulse that arrives too early or too late. A wrong shape latch or clear mask shows up only when the tile is read back after done: stale words outside the shape after a load, or words outside the zero area that were cleared. For that reason the bench compares every word of the tile after every command. Hint and direction faults show up on the first request of the affected operation.

// File: rtl/tte_pkg.sv
package tte_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STREAM = 2'd1,
        OP_STORE  = 2'd2,
        OP_ZERO   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } st_e;
endpackage

// File: rtl/tte_shape_check.sv
module tte_shape_check #(
    parameter int ROWS       = 16,
    parameter int ROW_BYTES  = 64,
    parameter int WORD_BYTES = 4,
    localparam int RCW = $clog2(ROWS + 1),
    localparam int BCW = $clog2(ROW_BYTES + 1),
    localparam int WPR = ROW_BYTES / WORD_BYTES,
    localparam int WCW = $clog2(WPR + 1)
) (
    input  logic           cfg_ok,
    input  logic [RCW-1:0] rows_in,
    input  logic [BCW-1:0] bytes_in,
    output logic           shape_ok,
    output logic [WCW-1:0] words_out
);
    logic rows_good;
    logic bytes_good;

    always_comb begin
        rows_good  = (rows_in != '0) && (rows_in <= RCW'(ROWS));
        bytes_good = (bytes_in != '0) && (bytes_in <= BCW'(ROW_BYTES))
                     && ((bytes_in % BCW'(WORD_BYTES)) == '0);
        shape_ok   = cfg_ok && rows_good && bytes_good;
        words_out  = WCW'(bytes_in / BCW'(WORD_BYTES));
    end
endmodule

// File: rtl/tte_tile_bank.sv
module tte_tile_bank #(
    parameter int NT   = 2,
    parameter int ROWS = 16,
    parameter int WPR  = 16,
    parameter int DW   = 32,
    localparam int TW  = (NT > 1) ? $clog2(NT) : 1,
    localparam int RIW = $clog2(ROWS),
    localparam int WIW = $clog2(WPR),
    localparam int RCW = $clog2(ROWS + 1),
    localparam int WCW = $clog2(WPR + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [TW-1:0]  wr_tile,
    input  logic [RIW-1:0] wr_row,
    input  logic [WIW-1:0] wr_word,
    input  logic [DW-1:0]  wr_data,
    input  logic           clr_en,
    input  logic [TW-1:0]  clr_tile,
    input  logic [RCW-1:0] clr_rows,
    input  logic [WCW-1:0] clr_words,
    input  logic [TW-1:0]  ra_tile,
    input  logic [RIW-1:0] ra_row,
    input  logic [WIW-1:0] ra_word,
    output logic [DW-1:0]  ra_data,
    input  logic [TW-1:0]  rb_tile,
    input  logic [RIW-1:0] rb_row,
    input  logic [WIW-1:0] rb_word,
    output logic [DW-1:0]  rb_data
);
    logic [DW-1:0] bank_d [NT][ROWS][WPR];
    logic [DW-1:0] bank_q [NT][ROWS][WPR];

    always_comb begin
        bank_d = bank_q;
        for (int t = 0; t < NT; t++) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int w = 0; w < WPR; w++) begin
                    if (clr_en && (TW'(t) == clr_tile) &&
                        (RCW'(r) < clr_rows) && (WCW'(w) < clr_words))
                        bank_d[t][r][w] = '0;
                end
            end
        end
        if (wr_en)
            bank_d[wr_tile][wr_row][wr_word] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '{default: '0};
        else        bank_q <= bank_d;
    end

    assign ra_data = bank_q[ra_tile][ra_row][ra_word];
    assign rb_data = bank_q[rb_tile][rb_row][rb_word];

    AST_WR_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en)); // R2
endmodule

// File: rtl/tile_xfer_engine.sv
module tile_xfer_engine
    import tte_pkg::*;
#(
    parameter int NT         = 2,
    parameter int ROWS       = 16,
    parameter int ROW_BYTES  = 64,
    parameter int WORD_BYTES = 4,
    parameter int AW         = 16,
    localparam int DW  = 8 * WORD_BYTES,
    localparam int WPR = ROW_BYTES / WORD_BYTES,
    localparam int TW  = (NT > 1) ? $clog2(NT) : 1,
    localparam int RIW = $clog2(ROWS),
    localparam int WIW = $clog2(WPR),
    localparam int RCW = $clog2(ROWS + 1),
    localparam int BCW = $clog2(ROW_BYTES + 1),
    localparam int WCW = $clog2(WPR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ok,
    input  logic [NT*RCW-1:0] cfg_rows,
    input  logic [NT*BCW-1:0] cfg_bytes,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [TW-1:0]     cmd_tile,
    input  logic [AW-1:0]     cmd_base,
    input  logic [AW-1:0]     cmd_stride,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_nt,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [TW-1:0]     tile_rd_tile,
    input  logic [RIW-1:0]    tile_rd_row,
    input  logic [WIW-1:0]    tile_rd_word,
    output logic [DW-1:0]     tile_rd_data
);
    typedef struct packed {
        st_e            st;
        op_e            op;
        logic [TW-1:0]  tile;
        logic [RCW-1:0] rows;
        logic [WCW-1:0] words;
        logic [RIW-1:0] row;
        logic [WIW-1:0] word;
        logic [AW-1:0]  row_base;
        logic [AW-1:0]  stride;
        logic           done;
        logic           err;
    } eng_t;

    eng_t s_d, s_q;

    // per-tile shape fields
    logic [RCW-1:0] rows_arr  [NT];
    logic [BCW-1:0] bytes_arr [NT];
    for (genvar gi = 0; gi < NT; gi++) begin : g_shape
        assign rows_arr[gi]  = cfg_rows[gi*RCW +: RCW];
        assign bytes_arr[gi] = cfg_bytes[gi*BCW +: BCW];
    end

    logic           shape_ok;
    logic [WCW-1:0] shape_words;

    tte_shape_check #(
        .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_shape (
        .cfg_ok   (cfg_ok),
        .rows_in  (rows_arr[cmd_tile]),
        .bytes_in (bytes_arr[cmd_tile]),
        .shape_ok (shape_ok),
        .words_out(shape_words)
    );

    logic           wr_en;
    logic           clr_en;
    logic [RCW-1:0] clr_rows;
    logic [WCW-1:0] clr_words;
    logic [DW-1:0]  tile_word;
    logic           last_word;
    logic           last_row;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.err   = 1'b0;
        wr_en     = 1'b0;
        clr_en    = 1'b0;
        clr_rows  = RCW'(ROWS);
        clr_words = WCW'(WPR);
        last_word = (s_q.word == WIW'(s_q.words - WCW'(1)));
        last_row  = (s_q.row == RIW'(s_q.rows - RCW'(1)));
        case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (!shape_ok) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.op       = op_e'(cmd_op);
                        s_d.tile     = cmd_tile;
                        s_d.rows     = rows_arr[cmd_tile];
                        s_d.words    = shape_words;
                        s_d.row      = '0;
                        s_d.word     = '0;
                        s_d.row_base = cmd_base;
                        s_d.stride   = cmd_stride;
                        s_d.st       = (op_e'(cmd_op) == OP_STORE) ? ST_ISSUE : ST_CLEAR;
                    end
                end
            end
            ST_CLEAR: begin
                clr_en = 1'b1;
                if (s_q.op == OP_ZERO) begin
                    clr_rows  = s_q.rows;
                    clr_words = s_q.words;
                    s_d.st    = ST_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.st = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_ack) begin
                    wr_en  = (s_q.op != OP_STORE);
                    s_d.st = ST_ISSUE;
                    if (last_word) begin
                        s_d.word = '0;
                        if (last_row) begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.row      = s_q.row + RIW'(1);
                            s_d.row_base = s_q.row_base + s_q.stride;
                        end
                    end else begin
                        s_d.word = s_q.word + WIW'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    tte_tile_bank #(.NT(NT), .ROWS(ROWS), .WPR(WPR), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_tile  (s_q.tile),
        .wr_row   (s_q.row),
        .wr_word  (s_q.word),
        .wr_data  (mem_rdata),
        .clr_en   (clr_en),
        .clr_tile (s_q.tile),
        .clr_rows (clr_rows),
        .clr_words(clr_words),
        .ra_tile  (s_q.tile),
        .ra_row   (s_q.row),
        .ra_word  (s_q.word),
        .ra_data  (tile_word),
        .rb_tile  (tile_rd_tile),
        .rb_row   (tile_rd_row),
        .rb_word  (tile_rd_word),
        .rb_data  (tile_rd_data)
    );

    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;
    assign err       = s_q.err;
    assign mem_req   = (s_q.st == ST_ISSUE);
    assign mem_we    = mem_req && (s_q.op == OP_STORE);
    assign mem_nt    = mem_req && (s_q.op == OP_STREAM);
    assign mem_addr  = s_q.row_base + AW'(s_q.word);
    assign mem_wdata = tile_word;

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R1
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R1
    AST_HINT_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_nt |-> (mem_req && !mem_we)); // R3
    AST_ZERO_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.op == OP_ZERO) |-> !mem_req); // R5
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R7
    AST_IDLE_STABLE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.words)); // R8
endmodule

// File: tb/tb_tile_xfer_engine.sv
module tb_tile_xfer_engine;
    localparam int NT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ok = 1'b0;
    logic [9:0]  cfg_rows = '0;
    logic [13:0] cfg_bytes = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_tile = 1'b0;
    logic [15:0] cmd_base = '0;
    logic [15:0] cmd_stride = '0;
    logic        busy, done, err, mem_req, mem_we, mem_nt;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tile_rd_tile = 1'b0;
    logic [3:0]  tile_rd_row = '0;
    logic [3:0]  tile_rd_word = '0;
    logic [31:0] tile_rd_data;

    always #10 clk = ~clk;

    tile_xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .cfg_rows(cfg_rows),
        .cfg_bytes(cfg_bytes), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_tile(cmd_tile), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .busy(busy), .done(done), .err(err), .mem_req(mem_req),
        .mem_we(mem_we), .mem_nt(mem_nt), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tile_rd_tile(tile_rd_tile), .tile_rd_row(tile_rd_row),
        .tile_rd_word(tile_rd_word), .tile_rd_data(tile_rd_data)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [31:0] bmem [4096];
    logic [31:0] model [NT][16][16];
    int          sh_rows [NT];
    int          sh_bytes [NT];

    logic [15:0] log_addr [300];
    logic        log_we [300];
    logic        log_nt [300];
    int          log_n = 0;

    // memory model: one outstanding request, ack after 1..3 cycles
    bit          pend = 1'b0;
    int          dly = 0;
    logic [15:0] paddr = '0;
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (pend) begin
            if (dly == 0) begin
                mem_ack   = 1'b1;
                mem_rdata = bmem[paddr[11:0]];
                pend      = 1'b0;
            end else begin
                dly--;
            end
        end else if (mem_req) begin
            pend  = 1'b1;
            paddr = mem_addr;
            dly   = int'($urandom % 3);
            if (mem_we) bmem[mem_addr[11:0]] = mem_wdata;
            if (log_n < 300) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
                log_nt[log_n]   = mem_nt;
            end
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_cfg();
        for (int t = 0; t < NT; t++) begin
            cfg_rows[t*5 +: 5]  = 5'(sh_rows[t]);
            cfg_bytes[t*7 +: 7] = 7'(sh_bytes[t]);
        end
    endtask

    task automatic check_tile(input int t, input string req);
        int mism = 0;
        longint fa = 0, fe = 0;
        for (int r = 0; r < 16; r++) begin
            for (int w = 0; w < 16; w++) begin
                tile_rd_tile = 1'(t);
                tile_rd_row  = 4'(r);
                tile_rd_word = 4'(w);
                #1;
                if (tile_rd_data !== model[t][r][w]) begin
                    if (mism == 0) begin
                        fa = longint'(tile_rd_data);
                        fe = longint'(model[t][r][w]);
                    end
                    mism++;
                end
            end
        end
        chk(mism == 0, req, $sformatf("tile %0d contents", t), fa, fe);
    endtask

    function automatic logic [15:0] exp_addr(int base, int stride, int r, int w);
        return 16'(base + r * stride + w);
    endfunction

    task automatic do_cmd(input int op, input int t, input int base, input int stride,
                          input bit exp_err, input bit poke);
        int rows, words, cyc, nexp, bad;
        string req;
        rows  = sh_rows[t];
        words = sh_bytes[t] / 4;
        req   = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = 2'(op);
        cmd_tile   = 1'(t);
        cmd_base   = 16'(base);
        cmd_stride = 16'(stride);
        log_n      = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (exp_err) begin
            chk(err && !busy, "R6", "err pulse without busy", {err, busy}, 2'b10);
            repeat (4) @(negedge clk);
            chk(log_n == 0 && !err, "R6", "no traffic after reject", log_n, 0);
            check_tile(t, "R6");
            return;
        end
        chk(busy && !err, "R7", "busy after accept", {busy, err}, 2'b10);
        if (op == 0 || op == 1) begin
            for (int r = 0; r < 16; r++)
                for (int w = 0; w < 16; w++)
                    model[t][r][w] = (r < rows && w < words) ?
                        bmem[exp_addr(base, stride, r, w) & 16'hFFF] : 32'h0;
        end else if (op == 3) begin
            for (int r = 0; r < rows; r++)
                for (int w = 0; w < words; w++)
                    model[t][r][w] = 32'h0;
        end
        if (poke) begin
            cmd_valid = 1'b1;
            cmd_op    = 2'd3;
            cmd_tile  = 1'(t ^ 1);
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done && !busy, "R7", "done pulse with busy low", {done, busy}, 2'b10);
        @(negedge clk);
        chk(!done && !busy, "R7", "done lasts one cycle", done, 0);
        check_tile(t, req);
        if (poke) begin
            chk(log_n == rows * words, "R8", "request count with ignored command",
                log_n, rows * words);
            check_tile(t ^ 1, "R8");
        end
        nexp = (op == 3) ? 0 : rows * words;
        chk(log_n == nexp, (op == 3) ? "R5" : "R1", "request count", log_n, nexp);
        bad = 0;
        for (int k = 0; k < nexp && k < 300; k++) begin
            if (log_addr[k] !== exp_addr(base, stride, k / words, k % words) ||
                log_we[k] !== (op == 2) || log_nt[k] !== (op == 1))
                bad++;
        end
        chk(bad == 0, "R1", "address/we sequence", bad, 0);
        if (op == 1 || op == 0) chk(bad == 0, "R3", "hint bit per request", bad, 0);
        if (op == 2) begin
            bad = 0;
            for (int r = 0; r < rows; r++)
                for (int w = 0; w < words; w++)
                    if (bmem[exp_addr(base, stride, r, w) & 16'hFFF] !== model[t][r][w])
                        bad++;
            chk(bad == 0, "R4", "stored words in memory", bad, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 4096; i++) bmem[i] = $urandom;
        for (int t = 0; t < NT; t++)
            for (int r = 0; r < 16; r++)
                for (int w = 0; w < 16; w++)
                    model[t][r][w] = 32'h0;
        sh_rows[0] = 16; sh_bytes[0] = 64;
        sh_rows[1] = 16; sh_bytes[1] = 64;
        drive_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!busy && !done && !err && !mem_req, "R9", "outputs after reset",
            {busy, done, err, mem_req}, 0);
        check_tile(0, "R9");
        check_tile(1, "R9");
        // R6: unconfigured
        do_cmd(0, 0, 0, 16, 1'b1, 1'b0);
        cfg_ok = 1'b1;
        // R1 R2: full plain load
        do_cmd(0, 0, 100, 16, 1'b0, 1'b0);
        // R3: full load then smaller streaming load, outside area zero
        do_cmd(0, 1, 500, 20, 1'b0, 1'b0);
        sh_rows[1] = 5; sh_bytes[1] = 24; drive_cfg();
        do_cmd(1, 1, 2000, 40, 1'b0, 1'b0);
        // R4: store full tile
        do_cmd(2, 0, 3000, 16, 1'b0, 1'b0);
        // R5: zero a 3x2 area
        sh_rows[0] = 3; sh_bytes[0] = 8; drive_cfg();
        do_cmd(3, 0, 0, 0, 1'b0, 1'b0);
        // R6: invalid shapes
        sh_rows[0] = 4; sh_bytes[0] = 6;  drive_cfg(); do_cmd(0, 0, 0, 8, 1'b1, 1'b0);
        sh_rows[0] = 0; sh_bytes[0] = 8;  drive_cfg(); do_cmd(2, 0, 0, 8, 1'b1, 1'b0);
        sh_rows[0] = 17; sh_bytes[0] = 8; drive_cfg(); do_cmd(3, 0, 0, 8, 1'b1, 1'b0);
        sh_rows[0] = 2; sh_bytes[0] = 68; drive_cfg(); do_cmd(1, 0, 0, 8, 1'b1, 1'b0);
        // R8: command during busy ignored; 1-row 1-word edge
        sh_rows[0] = 1; sh_bytes[0] = 4; sh_rows[1] = 16; sh_bytes[1] = 64; drive_cfg();
        do_cmd(0, 0, 4000, 1, 1'b0, 1'b1);
        sh_rows[0] = 16; sh_bytes[0] = 64; drive_cfg();
        do_cmd(1, 1, 7, 3, 1'b0, 1'b1);
        // random mix
        for (int i = 0; i < 40; i++) begin
            int t, op, wds, stride;
            t  = int'($urandom % 2);
            op = int'($urandom % 4);
            sh_rows[t]  = 1 + int'($urandom % 16);
            wds         = 1 + int'($urandom % 16);
            sh_bytes[t] = 4 * wds;
            drive_cfg();
            stride = (op == 2) ? wds + int'($urandom % (161 - wds))
                               : 1 + int'($urandom % 160);
            do_cmd(op, t, int'($urandom % 1024), stride, 1'b0, 1'b0);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule